// File: doc/BRIEF.md
# NOR Flash Write Guard

This block sits between the asynchronous parallel bus of a NOR flash device and its command state machine. It samples the three active-low strobes (chip enable, write enable, output enable) with an internal clock. It rejects short noise pulses and recognises a bus write only when chip enable and write enable are both asserted and output enable is released. When a write is recognised, it emits a one-cycle qualified strobe and latches the address and data seen at that moment.

The same logic keeps writes away from the command logic in two cases. The first is while a supply-lockout flag is raised. The second is after power-on reset, until a clean release of write enable or chip enable has been observed. In both cases it asks the rest of the controller to return to read mode.

A protection gate reports whether program or erase may go ahead on the sector group addressed by the latched write. A low level on the hardware protect pin forces one boundary group to be treated as protected, whatever its stored state. A parameter chooses whether that group is the lowest or the highest one.

Top module: `nor_write_guard`

## Requirements
- R1: A qualified strobe `wr_stb` (one cycle high) is produced only after filtered chip enable and filtered write enable are both low while filtered output enable is high.
- R2: Any one of output enable low, chip enable high or write enable high prevents a write: of the eight static strobe combinations, only ce_n=0, we_n=0, oe_n=1 produces a strobe.
- R3: A strobe level counts only after it has been seen for MIN_LOW consecutive clock samples. A write-enable and chip-enable low lasting fewer than MIN_LOW cycles gives no strobe. One lasting MIN_LOW cycles or longer gives exactly one strobe.
- R4: After a recognised write, write enable or chip enable must return high before another write can be recognised. Toggling output enable alone gives no second strobe, and `wr_stb` is never high in two consecutive cycles.
- R5: `wr_addr` and `wr_data` hold the values present on `addr` and `data` in the cycle the write was recognised, until the next write.
- R6: While `vlow` is high, no strobe is produced, `force_read` is high and `pe_ok` is low.
- R7: After `vlow` falls, writes resume only once write enable or chip enable has been seen high. A write held across the recovery gives no strobe.
- R8: After power-on reset, `force_read` stays high and no strobe is produced until write enable or chip enable has been seen high. A write held low through reset release is ignored.
- R9: While `wp_n` is low, `pe_ok` is low when the latched address selects the guarded group, whatever that group's stored protection bit is. The group number is the top GRP_W bits of the address.
- R10: While `wp_n` is high, `pe_ok` for every group equals the inverse of that group's stored bit in `grp_prot` (bit index = group number), given the block is armed and `vlow` is low.
- R11: With GUARD_TOP=0 the guarded group is group 0. With GUARD_TOP=1 it is group 2**GRP_W-1. `wp_n` has no effect on any other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Power-on reset, active low |
| ce_n | input | 1 | Chip enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| wp_n | input | 1 | Hardware protect, active low; pulled high at the pad |
| vlow | input | 1 | Supply below lockout threshold |
| addr | input | ADDR_W | Bus address |
| data | input | DATA_W | Bus data |
| grp_prot | input | 2**GRP_W | Stored protection bit per sector group |
| wr_stb | output | 1 | Qualified write strobe, one cycle |
| wr_addr | output | ADDR_W | Address latched with the last write |
| wr_data | output | DATA_W | Data latched with the last write |
| pe_ok | output | 1 | Program/erase allowed on the latched group |
| force_read | output | 1 | Request to return to read mode |

## Verification
Strobe pulses are swept in length from one cycle up to past MIN_LOW, which locates the exact glitch threshold. All eight static strobe combinations are applied to separate the single legal write pattern from every inhibiting one. Sequences that hold the write pattern across reset release, across supply recovery and across an output-enable toggle show whether arming and re-arming depend on a real release. A sweep of every group, stored bit and protect-pin level runs on two instances, one guarding the lowest group and one guarding the highest. This shows that the override follows the selected boundary only.

// File: rtl/nwg_pkg.sv
package nwg_pkg;

  typedef enum logic [1:0] {
    ARM_WAIT  = 2'd0,
    ARM_READY = 2'd1,
    ARM_HOLD  = 2'd2
  } arm_state_e;

  // Selected group is the guarded boundary group
  function automatic logic guard_hit(input int unsigned grp,
                                     input int unsigned ngrp,
                                     input bit          top);
    return top ? (grp == ngrp - 1) : (grp == 0);
  endfunction

  // Program/erase permitted given stored bit, guard hit and pin level
  function automatic logic pe_permit(input logic stored,
                                     input logic guarded,
                                     input logic pin_n);
    return !(stored || (guarded && !pin_n));
  endfunction

endpackage

// File: rtl/nwg_strobe_filter.sv
module nwg_strobe_filter #(
  parameter int SYNC    = 2,
  parameter int MIN_LOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic low_q
);
  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

  logic [SYNC-1:0]  sr;
  logic [CNT_W-1:0] cnt;
  logic             s_pin;

  assign s_pin = sr[SYNC-1];

  // Reset state reads as asserted, so a release must really be observed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= CNT_MAX;
    end else begin
      sr <= {sr[SYNC-2:0], pin_n};
      if (s_pin)
        cnt <= '0;
      else if (cnt != CNT_MAX)
        cnt <= cnt + CNT_W'(1);
    end
  end

  assign low_q = (cnt == CNT_MAX);
endmodule

// File: rtl/nwg_qualifier.sv
module nwg_qualifier
  import nwg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vlow,
  input  logic              ce_low,
  input  logic              we_low,
  input  logic              oe_low,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              armed,
  output logic              take
);
  arm_state_e st, st_nx;
  logic cond, released;

  always_comb begin
    cond     = ce_low && we_low && !oe_low;
    released = !ce_low || !we_low;
    take     = (st == ARM_READY) && cond && !vlow;
    st_nx    = st;
    if (vlow) begin
      st_nx = ARM_WAIT;
    end else begin
      unique case (st)
        ARM_WAIT:  if (released) st_nx = ARM_READY;
        ARM_READY: if (take)     st_nx = ARM_HOLD;
        ARM_HOLD:  if (released) st_nx = ARM_READY;
        default:                 st_nx = ARM_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ARM_WAIT;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      st     <= st_nx;
      wr_stb <= take;
      if (take) begin
        wr_addr <= addr;
        wr_data <= data;
      end
    end
  end

  assign armed = (st != ARM_WAIT);
endmodule

// File: rtl/nwg_prot_gate.sv
module nwg_prot_gate
  import nwg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int GRP_W     = 3,
  parameter bit GUARD_TOP = 1'b0
) (
  input  logic                  armed,
  input  logic                  vlow,
  input  logic                  wp_n,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [(1<<GRP_W)-1:0] grp_prot,
  output logic                  guard_sel,
  output logic                  stored_sel,
  output logic                  pe_ok
);
  localparam int NGRP = 1 << GRP_W;

  logic [GRP_W-1:0] grp;

  always_comb begin
    grp        = wr_addr[ADDR_W-1 -: GRP_W];
    guard_sel  = guard_hit(32'(grp), NGRP, GUARD_TOP);
    stored_sel = grp_prot[grp];
    pe_ok      = armed && !vlow && pe_permit(stored_sel, guard_sel, wp_n);
  end
endmodule

// File: rtl/nor_write_guard.sv
module nor_write_guard #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int GRP_W     = 3,
  parameter int MIN_LOW   = 3,
  parameter int SYNC      = 2,
  parameter bit GUARD_TOP = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_n,
  input  logic                  we_n,
  input  logic                  oe_n,
  input  logic                  wp_n,
  input  logic                  vlow,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     data,
  input  logic [(1<<GRP_W)-1:0] grp_prot,
  output logic                  wr_stb,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  output logic                  pe_ok,
  output logic                  force_read
);
  localparam int NSTB = 3;  // 0: chip enable, 1: write enable, 2: output enable

  logic [NSTB-1:0] pins_n;
  logic [NSTB-1:0] flt_low;
  logic            flt_ce_low, flt_we_low, flt_oe_low;
  logic            armed, take, guard_sel, stored_sel;

  assign pins_n = {oe_n, we_n, ce_n};

  for (genvar i = 0; i < NSTB; i++) begin : g_flt
    nwg_strobe_filter #(.SYNC(SYNC), .MIN_LOW(MIN_LOW)) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (pins_n[i]),
      .low_q (flt_low[i])
    );
  end

  assign flt_ce_low = flt_low[0];
  assign flt_we_low = flt_low[1];
  assign flt_oe_low = flt_low[2];

  nwg_qualifier #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .vlow    (vlow),
    .ce_low  (flt_ce_low),
    .we_low  (flt_we_low),
    .oe_low  (flt_oe_low),
    .addr    (addr),
    .data    (data),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .armed   (armed),
    .take    (take)
  );

  nwg_prot_gate #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .GUARD_TOP(GUARD_TOP)) u_prot (
    .armed      (armed),
    .vlow       (vlow),
    .wp_n       (wp_n),
    .wr_addr    (wr_addr),
    .grp_prot   (grp_prot),
    .guard_sel  (guard_sel),
    .stored_sel (stored_sel),
    .pe_ok      (pe_ok)
  );

  assign force_read = vlow || !armed;
endmodule

// File: rtl/nwg_checker.sv
module nwg_checker (
  input logic clk,
  input logic rst_n,
  input logic vlow,
  input logic wp_n,
  input logic wr_stb,
  input logic pe_ok,
  input logic force_read,
  input logic flt_ce_low,
  input logic flt_we_low,
  input logic flt_oe_low,
  input logic guard_sel,
  input logic stored_sel
);
  // R1
  legal_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(flt_ce_low && flt_we_low && !flt_oe_low));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R6
  lockout_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vlow |=> !wr_stb);

  // R6
  lockout_pe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vlow |-> (!pe_ok && force_read));

  // R8
  unarmed_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_read |=> !wr_stb);

  // R9
  wp_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_sel && !wp_n) |-> !pe_ok);

  // R10
  stored_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stored_sel |-> !pe_ok);
endmodule

bind nor_write_guard nwg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vlow       (vlow),
  .wp_n       (wp_n),
  .wr_stb     (wr_stb),
  .pe_ok      (pe_ok),
  .force_read (force_read),
  .flt_ce_low (flt_ce_low),
  .flt_we_low (flt_we_low),
  .flt_oe_low (flt_oe_low),
  .guard_sel  (guard_sel),
  .stored_sel (stored_sel)
);

// File: tb/nor_write_guard_tb.sv
module nor_write_guard_tb;
  localparam int AW = 8, DW = 8, GW = 3, ML = 3, NG = 1 << GW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wp_n = 1'b1, vlow = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [NG-1:0] grp_prot = '0;
  logic          stb0, stb1, pe0, pe1, fr0, fr1;
  logic [AW-1:0] wa0, wa1;
  logic [DW-1:0] wd0, wd1;
  int n_tests = 0, n_fail = 0, cnt0 = 0, cnt1 = 0, cyc = 0;

  always #5 clk = ~clk;

  nor_write_guard #(.ADDR_W(AW), .DATA_W(DW), .GRP_W(GW), .MIN_LOW(ML),
                    .GUARD_TOP(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wp_n(wp_n), .vlow(vlow), .addr(addr), .data(data), .grp_prot(grp_prot),
    .wr_stb(stb0), .wr_addr(wa0), .wr_data(wd0), .pe_ok(pe0), .force_read(fr0));

  nor_write_guard #(.ADDR_W(AW), .DATA_W(DW), .GRP_W(GW), .MIN_LOW(ML),
                    .GUARD_TOP(1'b1)) u_dut_top (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wp_n(wp_n), .vlow(vlow), .addr(addr), .data(data), .grp_prot(grp_prot),
    .wr_stb(stb1), .wr_addr(wa1), .wr_data(wd1), .pe_ok(pe1), .force_read(fr1));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (stb0) cnt0 <= cnt0 + 1;
    if (stb1) cnt1 <= cnt1 + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Hold a strobe pattern for len cycles, then release all strobes
  task automatic drive(input logic c, input logic w, input logic o, input int len);
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o;
    idle(len);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    idle(8);
  endtask

  initial begin : watchdog
    wait (cyc > 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int base;
    // Reset state, with a write held low across reset release (R8)
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    idle(4);
    chk(!stb0 && fr0 && !pe0, "R8 reset state", {stb0, fr0, pe0}, 3'b010);
    rst_n = 1'b1;
    idle(12);
    chk(cnt0 == 0, "R8 held write after reset ignored", cnt0, 0);
    chk(fr0 == 1'b1, "R8 force_read before arming", fr0, 1);
    we_n = 1'b1;
    idle(8);
    chk(fr0 == 1'b0, "R8 armed after release", fr0, 0);
    ce_n = 1'b1;
    idle(4);

    // R3 / R1 / R5: pulse length sweep
    for (int len = 1; len <= ML + 3; len++) begin
      base = cnt0;
      addr = AW'(8'h10 + len); data = DW'(8'hA0 + len);
      drive(1'b0, 1'b0, 1'b1, len);
      chk(cnt0 - base == ((len >= ML) ? 1 : 0), "R3 pulse length threshold",
          cnt0 - base, (len >= ML) ? 1 : 0);
      if (len >= ML) begin
        chk(wa0 == AW'(8'h10 + len), "R5 address latched", int'(wa0), 8'h10 + len);
        chk(wd0 == DW'(8'hA0 + len), "R5 data latched", int'(wd0), 8'hA0 + len);
      end
    end

    // R2 / R1: all strobe combinations
    for (int k = 0; k < 8; k++) begin
      base = cnt0;
      drive(k[2], k[1], k[0], ML + 3);
      chk(cnt0 - base == ((k == 1) ? 1 : 0), "R2 strobe combination",
          cnt0 - base, (k == 1) ? 1 : 0);
    end

    // R4: output enable toggled while the write is held
    base = cnt0;
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    idle(8); oe_n = 1'b0; idle(8); oe_n = 1'b1; idle(8);
    ce_n = 1'b1; we_n = 1'b1; idle(8);
    chk(cnt0 - base == 1, "R4 one strobe until release", cnt0 - base, 1);
    // R4: release of write enable alone re-arms
    base = cnt0;
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; idle(8);
    we_n = 1'b1; idle(8); we_n = 1'b0; idle(8);
    ce_n = 1'b1; we_n = 1'b1; idle(8);
    chk(cnt0 - base == 2, "R4 release then new write", cnt0 - base, 2);

    // R6: supply lockout
    @(negedge clk); vlow = 1'b1;
    @(negedge clk);
    chk(fr0 && !pe0, "R6 lockout outputs", {fr0, pe0}, 2'b10);
    base = cnt0;
    drive(1'b0, 1'b0, 1'b1, ML + 4);
    chk(cnt0 == base, "R6 write during lockout ignored", cnt0 - base, 0);

    // R7: write held across supply recovery
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    idle(8); vlow = 1'b0; idle(10);
    chk(cnt0 == base, "R7 held write after recovery ignored", cnt0 - base, 0);
    ce_n = 1'b1; we_n = 1'b1; idle(8);
    drive(1'b0, 1'b0, 1'b1, ML + 2);
    chk(cnt0 - base == 1, "R7 write accepted after release", cnt0 - base, 1);

    // R9 / R10 / R11: group x stored bit x protect pin, both guard choices
    for (int g = 0; g < NG; g++) begin
      for (int s = 0; s < 2; s++) begin
        for (int w = 0; w < 2; w++) begin
          grp_prot = s ? NG'(1 << g) : '0;
          wp_n = w[0];
          addr = AW'((g << (AW - GW)) | 5);
          drive(1'b0, 1'b0, 1'b1, ML + 2);
          chk(pe0 == !(s == 1 || (g == 0 && w == 0)),
              (w == 0) ? "R9 low guard pe_ok" : "R10 low guard pe_ok",
              pe0, !(s == 1 || (g == 0 && w == 0)));
          chk(pe1 == !(s == 1 || (g == NG - 1 && w == 0)),
              "R11 high guard pe_ok", pe1, !(s == 1 || (g == NG - 1 && w == 0)));
        end
      end
    end
    chk(cnt1 == cnt0, "R11 both instances see same writes", cnt1, cnt0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule